// File: doc/BRIEF.md
# Feedback Divider with Cycle Slip

This block holds the two digital counters that sit in front of a phase detector in a frequency-translating PLL. The feedback counter runs on the oscillator clock and emits a one-cycle terminal pulse every M clocks. The reference counter advances on a one-cycle reference enable and emits a terminal pulse every R enables. A lock loop built around these pulses settles the oscillator at the reference rate scaled by M/R. Both moduli come from a configuration register. A new value takes effect only when the matching counter wraps.

Two request inputs, add and drop, let the system slip the oscillator by one whole cycle relative to the reference. This is used to re-centre an elastic data buffer. A rising edge on a request is held until the next reference terminal pulse. The feedback period that starts at the following feedback terminal pulse then lasts M+1 clocks (add) or M-1 clocks (drop). After that single period the count returns to M. Each phase-detector period accepts at most one request. A slip status pulse marks every modified period that is actually applied. An auxiliary clock-enable output runs at the oscillator rate or at one quarter of it.

Top module: `fb_slip_divider`

## Requirements
- R1: After reset the feedback counter uses a modulus of 32 and the reference counter a modulus of 1. The first `fb_tc_o` appears on the 31st rising edge after reset is released. The first `ref_en_i` pulse produces `ref_tc_o`, whatever `cfg_r_i` holds. During reset `fb_tc_o`, `ref_tc_o` and `slip_o` are low.
- R2: `ref_tc_o` is high for one clock. It rises one clock after the `ref_en_i` pulse that completes R enables. A `cfg_r_i` of 0 is treated as 1.
- R3: With no slip pending, consecutive `fb_tc_o` pulses are M clocks apart. A `cfg_m_i` below 3 is treated as 3.
- R4: A rising edge on `add_i` is held until the next `ref_tc_o`. The feedback period that begins at the first `fb_tc_o` after that reference pulse lasts M+1 clocks. Later periods last M.
- R5: A rising edge on `drop_i` behaves as in R4, except that the modified period lasts M-1 clocks.
- R6: A phase-detector period runs from one `ref_tc_o` up to the next. Only the first request edge in such a period is accepted. Later add or drop edges in the same period cause no slip.
- R7: Rising edges on `add_i` and `drop_i` in the same clock cancel. No slip results, the period stays M, and these edges still use up the request slot of that phase-detector period.
- R8: `slip_o` pulses for one clock, one clock after the `fb_tc_o` that starts a modified period. It pulses exactly once per applied slip.
- R9: A change to `cfg_m_i` or `cfg_r_i` part-way through a period does not alter that period. The new modulus starts at the next terminal count of that counter.
- R10: With `aux_div4_i` low, `aux_o` is high on every clock. With it high, `aux_o` is high on one clock in four, from a free-running counter that the slip logic does not touch. Each applied add slip therefore moves the feedback pulse phase by one clock, a quarter of an auxiliary period, relative to `aux_o`.
- R11: Only rising edges request a slip. A request input held high across several phase-detector periods produces one slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_en_i | input | 1 | One-clock reference enable pulse |
| cfg_m_i | input | 10 | Feedback modulus M from the configuration register |
| cfg_r_i | input | 9 | Reference modulus R from the configuration register |
| add_i | input | 1 | Add-one-cycle request (rising edge) |
| drop_i | input | 1 | Drop-one-cycle request (rising edge) |
| aux_div4_i | input | 1 | Auxiliary output select: 1 = divide by 4, 0 = divide by 1 |
| ref_tc_o | output | 1 | Reference terminal pulse to the phase detector |
| fb_tc_o | output | 1 | Feedback terminal pulse to the phase detector |
| aux_o | output | 1 | Auxiliary clock-enable tick |
| slip_o | output | 1 | One-clock pulse per applied slip |

## Verification
The bench measures the spacing between feedback pulses around every request. A design that applied a slip before the reference pulse, or kept it for more than one period, would show a wrong period length or a second long or short period. Several edges in one phase-detector period, simultaneous add and drop edges, and a request held high are each checked against the slip count. A design without arbitration, cancellation or edge detection would show extra slips there. Configuration changes in mid-period and moduli below the legal minimum check that a new modulus waits for the wrap and is clamped, and not applied at once. The phase of the auxiliary tick relative to the feedback pulse is compared before and after an add slip, to catch a divider that the slip logic resets.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE = 2'd0,
    SLIP_ADD  = 2'd1,
    SLIP_DROP = 2'd2
  } slip_e;
endpackage

// File: rtl/fdiv_slip_arb.sv
module fdiv_slip_arb
  import fdiv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  add_i,
  input  logic  drop_i,
  input  logic  ref_tc_i,
  input  logic  fb_tc_i,
  output slip_e arm_o
);
  logic  add_q, drop_q, lock_q;
  logic  add_edge, drop_edge, any_edge;
  slip_e pend_q, arm_q, req_val;

  assign add_edge  = add_i & ~add_q;
  assign drop_edge = drop_i & ~drop_q;
  assign any_edge  = add_edge | drop_edge;

  always_comb begin
    if (add_edge && drop_edge) req_val = SLIP_NONE;  // cancel
    else if (add_edge)         req_val = SLIP_ADD;
    else if (drop_edge)        req_val = SLIP_DROP;
    else                       req_val = SLIP_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_q  <= 1'b0;
      drop_q <= 1'b0;
      lock_q <= 1'b0;
      pend_q <= SLIP_NONE;
      arm_q  <= SLIP_NONE;
    end else begin
      add_q  <= add_i;
      drop_q <= drop_i;
      // armed slip is consumed by the reload that uses it
      if (fb_tc_i) arm_q <= SLIP_NONE;
      if (ref_tc_i) begin
        // new phase-detector period: hand over, reopen slot
        if (pend_q != SLIP_NONE) arm_q <= pend_q;
        pend_q <= req_val;
        lock_q <= any_edge;
      end else if (!lock_q && any_edge) begin
        pend_q <= req_val;
        lock_q <= 1'b1;
      end
    end
  end

  assign arm_o = arm_q;

  p_locked_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !ref_tc_i) |=> $stable(pend_q));

  p_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_edge && drop_edge && !lock_q && !ref_tc_i) |=> (pend_q == SLIP_NONE && lock_q));

  p_level_no_retrigger_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_q && add_i && drop_q && drop_i && !ref_tc_i) |=> $stable(pend_q));
endmodule

// File: rtl/fdiv_fb_counter.sv
module fdiv_fb_counter
  import fdiv_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int M_DEF = 32,
  parameter int M_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] cfg_m_i,
  input  slip_e          arm_i,
  output logic           fb_tc_o,
  output logic           slip_o
);
  localparam int CNT_W = M_W + 1;  // room for M+1

  logic [CNT_W-1:0] cnt_q, base_mod, next_mod;
  logic             slip_q;

  always_comb begin
    base_mod = {1'b0, cfg_m_i};
    if (base_mod < CNT_W'(M_MIN)) base_mod = CNT_W'(M_MIN);
    case (arm_i)
      SLIP_ADD:  next_mod = base_mod + CNT_W'(1);
      SLIP_DROP: next_mod = base_mod - CNT_W'(1);
      default:   next_mod = base_mod;
    endcase
  end

  assign fb_tc_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(M_DEF - 1);
      slip_q <= 1'b0;
    end else if (fb_tc_o) begin
      cnt_q  <= next_mod - CNT_W'(1);
      slip_q <= (arm_i != SLIP_NONE);
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
      slip_q <= 1'b0;
    end
  end

  assign slip_o = slip_q;

  p_reload_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_tc_o |=> (cnt_q >= CNT_W'(M_MIN - 2)));

  p_slip_needs_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> $past(arm_i != SLIP_NONE));
endmodule

// File: rtl/fdiv_ref_counter.sv
module fdiv_ref_counter #(
  parameter int R_W   = 9,
  parameter int R_DEF = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_en_i,
  input  logic [R_W-1:0] cfg_r_i,
  output logic           ref_tc_o
);
  logic [R_W-1:0] cnt_q, reload;
  logic           tc_q;

  assign reload = (cfg_r_i == '0) ? '0 : cfg_r_i - R_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= R_W'(R_DEF - 1);
      tc_q  <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (ref_en_i) begin
        if (cnt_q == '0) begin
          tc_q  <= 1'b1;
          cnt_q <= reload;
        end else begin
          cnt_q <= cnt_q - R_W'(1);
        end
      end
    end
  end

  assign ref_tc_o = tc_q;

  p_ref_tc_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tc_o |-> $past(ref_en_i));

  p_ref_tc_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tc_o |=> !ref_tc_o || $past(ref_en_i));
endmodule

// File: rtl/fdiv_aux_div.sv
module fdiv_aux_div #(
  parameter int AUX_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic aux_o
);
  if (AUX_DIV > 1) begin : g_cnt
    localparam int AUX_W = $clog2(AUX_DIV);
    logic [AUX_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == AUX_W'(AUX_DIV - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + AUX_W'(1);
    end

    assign aux_o = sel_i ? wrap : 1'b1;

    p_aux_sparse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && aux_o) |=> (!aux_o || !sel_i));
  end else begin : g_pass
    logic unused_sel;
    assign unused_sel = sel_i;
    assign aux_o      = 1'b1;
  end
endmodule

// File: rtl/fb_slip_divider.sv
module fb_slip_divider
  import fdiv_pkg::*;
#(
  parameter int M_W     = 10,
  parameter int R_W     = 9,
  parameter int M_DEF   = 32,
  parameter int R_DEF   = 1,
  parameter int M_MIN   = 3,
  parameter int AUX_DIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_en_i,
  input  logic [M_W-1:0] cfg_m_i,
  input  logic [R_W-1:0] cfg_r_i,
  input  logic           add_i,
  input  logic           drop_i,
  input  logic           aux_div4_i,
  output logic           ref_tc_o,
  output logic           fb_tc_o,
  output logic           aux_o,
  output logic           slip_o
);
  slip_e arm;
  logic  ref_tc, fb_tc;

  fdiv_ref_counter #(.R_W(R_W), .R_DEF(R_DEF)) i_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_en_i (ref_en_i),
    .cfg_r_i  (cfg_r_i),
    .ref_tc_o (ref_tc)
  );

  fdiv_slip_arb i_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .add_i    (add_i),
    .drop_i   (drop_i),
    .ref_tc_i (ref_tc),
    .fb_tc_i  (fb_tc),
    .arm_o    (arm)
  );

  fdiv_fb_counter #(.M_W(M_W), .M_DEF(M_DEF), .M_MIN(M_MIN)) i_fb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_m_i (cfg_m_i),
    .arm_i   (arm),
    .fb_tc_o (fb_tc),
    .slip_o  (slip_o)
  );

  fdiv_aux_div #(.AUX_DIV(AUX_DIV)) i_aux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (aux_div4_i),
    .aux_o  (aux_o)
  );

  assign ref_tc_o = ref_tc;
  assign fb_tc_o  = fb_tc;

  p_slip_after_tc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> $past(fb_tc_o));

  p_slip_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o);
endmodule

// File: tb/test_fb_slip_divider.sv
`timescale 1ns/1ps
module test_fb_slip_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic [9:0] cfg_m = 10'd20;
  logic [8:0] cfg_r = 9'd3;
  logic       add = 1'b0, drop = 1'b0, div4 = 1'b0;
  logic       ref_tc, fb_tc, aux, slip;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int slip_total = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && slip) slip_total++;

  fb_slip_divider i_fb_slip_divider (
    .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .cfg_m_i(cfg_m), .cfg_r_i(cfg_r),
    .add_i(add), .drop_i(drop), .aux_div4_i(div4),
    .ref_tc_o(ref_tc), .fb_tc_o(fb_tc), .aux_o(aux), .slip_o(slip)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fb(output int t);
    do @(negedge clk); while (!fb_tc);
    t = cyc;
  endtask

  task automatic pulse_ref(output bit tc);
    @(negedge clk) ref_en = 1'b1;
    @(negedge clk) begin tc = ref_tc; ref_en = 1'b0; end
  endtask

  task automatic pulse_add();
    @(negedge clk) add = 1'b1;
    @(negedge clk) add = 1'b0;
  endtask

  task automatic pulse_drop();
    @(negedge clk) drop = 1'b1;
    @(negedge clk) drop = 1'b0;
  endtask

  // ref pulse, then gaps of the two feedback periods that follow
  task automatic after_ref(output int g1, output int g2, output bit s, output int t2);
    bit tc; int t0, t1;
    pulse_ref(tc);
    chk(tc, "R6 ref pulse", tc, 1);
    wait_fb(t0);
    @(negedge clk) s = slip;
    wait_fb(t1);
    wait_fb(t2);
    g1 = t1 - t0;
    g2 = t2 - t1;
  endtask

  task automatic t_reset();
    int t_rel, t1, t2; bit tc;
    repeat (3) @(negedge clk);
    chk(!fb_tc && !ref_tc && !slip, "R1 reset outputs", {fb_tc, ref_tc, slip}, 0);
    @(negedge clk) begin rst_n = 1'b1; t_rel = cyc; end
    wait_fb(t1);
    chk(t1 - t_rel == 31, "R1 first feedback pulse", t1 - t_rel, 31);
    wait_fb(t2);
    chk(t2 - t1 == 20, "R3 period M", t2 - t1, 20);
    pulse_ref(tc);
    chk(tc, "R1 default R of 1", tc, 1);
  endtask

  task automatic t_ref_div();
    bit tc;
    pulse_ref(tc); chk(!tc, "R2 count 1 of 3", tc, 0);
    pulse_ref(tc); chk(!tc, "R2 count 2 of 3", tc, 0);
    pulse_ref(tc); chk(tc, "R2 terminal at 3", tc, 1);
    cfg_r = 9'd0;
    pulse_ref(tc); chk(!tc, "R9 R change waits", tc, 0);
    pulse_ref(tc); chk(!tc, "R9 R change waits", tc, 0);
    pulse_ref(tc); chk(tc, "R9 old period ends", tc, 1);
    pulse_ref(tc); chk(tc, "R2 R of 0 as 1", tc, 1);
    cfg_r = 9'd1;
    pulse_ref(tc); chk(tc, "R2 R of 1", tc, 1);
  endtask

  task automatic t_m_clamp();
    int t0, t1, t2;
    cfg_m = 10'd1;
    wait_fb(t0); wait_fb(t1); wait_fb(t2);
    chk(t1 - t0 == 3 && t2 - t1 == 3, "R3 M below 3 clamped", t2 - t1, 3);
    cfg_m = 10'd20;
    wait_fb(t0);
  endtask

  task automatic t_cfg_mid();
    int t0, t1, t2;
    wait_fb(t0);
    repeat (5) @(negedge clk);
    cfg_m = 10'd24;
    wait_fb(t1); wait_fb(t2);
    chk(t1 - t0 == 20, "R9 current period kept", t1 - t0, 20);
    chk(t2 - t1 == 24, "R9 new M at wrap", t2 - t1, 24);
    cfg_m = 10'd20;
    wait_fb(t0);
  endtask

  task automatic t_add();
    int g1, g2, t, t2; bit s;
    wait_fb(t);
    pulse_add();
    after_ref(g1, g2, s, t2);
    chk(g1 == 21, "R4 add period M+1", g1, 21);
    chk(g2 == 20, "R4 back to M", g2, 20);
    chk(s, "R8 slip pulse after add", s, 1);
  endtask

  task automatic t_drop();
    int g1, g2, t, t2; bit s;
    wait_fb(t);
    pulse_drop();
    after_ref(g1, g2, s, t2);
    chk(g1 == 19, "R5 drop period M-1", g1, 19);
    chk(g2 == 20, "R5 back to M", g2, 20);
    chk(s, "R8 slip pulse after drop", s, 1);
  endtask

  task automatic t_one_per_cycle();
    int g1, g2, t, t2, s0; bit s;
    wait_fb(t);
    s0 = slip_total;
    pulse_add(); pulse_add(); pulse_drop();
    after_ref(g1, g2, s, t2);
    chk(g1 == 21 && g2 == 20, "R6 only first request", g1, 21);
    after_ref(g1, g2, s, t2);
    chk(g1 == 20 && g2 == 20, "R6 later edges dropped", g1, 20);
    chk(slip_total - s0 == 1, "R6 slip count", slip_total - s0, 1);
  endtask

  task automatic t_cancel();
    int g1, g2, t, t2, s0; bit s;
    wait_fb(t);
    s0 = slip_total;
    @(negedge clk) begin add = 1'b1; drop = 1'b1; end
    @(negedge clk) begin add = 1'b0; drop = 1'b0; end
    pulse_add();
    after_ref(g1, g2, s, t2);
    chk(g1 == 20 && g2 == 20, "R7 add+drop cancel", g1, 20);
    chk(slip_total - s0 == 0, "R7 no slip", slip_total - s0, 0);
  endtask

  task automatic t_level();
    int g1, g2, t, t2, s0; bit s;
    wait_fb(t);
    s0 = slip_total;
    @(negedge clk) add = 1'b1;
    after_ref(g1, g2, s, t2);
    chk(g1 == 21, "R11 edge gives slip", g1, 21);
    after_ref(g1, g2, s, t2);
    chk(g1 == 20, "R11 held level ignored", g1, 20);
    chk(slip_total - s0 == 1, "R11 slip count", slip_total - s0, 1);
    @(negedge clk) add = 1'b0;
  endtask

  task automatic t_aux();
    int hi, ta, t0, g1, g2, t2, ph0, ph1; bit s; bit prev;
    div4 = 1'b0; hi = 0;
    repeat (8) @(negedge clk) if (aux) hi++;
    chk(hi == 8, "R10 divide by 1", hi, 8);
    div4 = 1'b1; hi = 0; prev = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (aux) begin
        hi++;
        chk(!prev, "R10 no back-to-back ticks", 1, 0);
      end
      prev = aux;
    end
    chk(hi == 4, "R10 divide by 4", hi, 4);
    do @(negedge clk); while (!aux);
    ta = cyc;
    wait_fb(t0);
    ph0 = (t0 - ta) % 4;
    pulse_add();
    after_ref(g1, g2, s, t2);
    ph1 = (t2 - ta) % 4;
    chk(ph1 == (ph0 + 1) % 4, "R10 quarter-cycle phase move", ph1, (ph0 + 1) % 4);
    div4 = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ref_div();
    t_m_clamp();
    t_cfg_mid();
    t_add();
    t_drop();
    t_one_per_cycle();
    t_cancel();
    t_level();
    t_aux();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule